// File: doc/BRIEF.md
# Green-Mode PWM Switching Timebase

This block produces the switching cycle for a peak-current-mode flyback controller. It takes a digitised feedback code and a current-sense comparator flag. It drives a gate request, a blanking flag and a soft-start reference code for the peak-current comparator. The analog comparators and the output driver sit outside it.

At normal load each switching period is a fixed count. As the feedback code falls through the green band, the period count stretches linearly toward the light-load value. A triangular hop is laid over the period to spread its spectrum, and the hop depth tracks the same band. At very light load, a hysteretic skip region withholds whole pulses. Within each pulse the on-time is capped at a fixed fraction of the period. Current-sense trips are masked for a short window after turn-on. After enable, the current reference ramps up from zero.

The feedback code has an LSB of 1/256 V. With the default parameters, 2.0 V is code 512, 2.1 V is code 538, 2.3 V is code 589 and 2.8 V is code 717.

Top module: `gmpwm_timebase`

## Requirements
- R1: While reset is held, `gate_o` and `blank_o` are low and `cs_ref_o` is zero.
- R2: With `fb_i` at or above FB_GREEN + 2^BAND_LG, the base period is PER_NORM clocks. The mean over any 2^(HOP_LG+1) consecutive cycles equals PER_NORM.
- R3: For FB_GREEN < `fb_i` < FB_GREEN + 2^BAND_LG, let inv = FB_GREEN + 2^BAND_LG − `fb_i`. The base period is PER_NORM + ((PER_GREEN − PER_NORM)·inv >> BAND_LG), and the hop depth is HOP_NORM + ((HOP_GREEN − HOP_NORM)·inv >> BAND_LG). At or below FB_GREEN, inv is 2^BAND_LG.
- R4: A hop index starts at 0 after reset. It steps once per cycle up to 2^HOP_LG, then back down to 0, and repeats. Each cycle lasts base − depth/2 + ((depth·index) >> HOP_LG) clocks, using that cycle's index.
- R5: With no trip, each pulse lasts (period·DUTY_Q7) >> 7 clocks of its own cycle, starting on the cycle's first clock.
- R6: `blank_o` is high for the first LEB_CYC clocks of each pulse, and a trip during those clocks is ignored.
- R7: A trip sampled on an unblanked pulse clock drops `gate_o` on the next clock. The gate stays low until the next cycle starts.
- R8: Pulses stop once `fb_i` < FB_STOP and resume only once `fb_i` > FB_RESUME. Codes in between keep the current state.
- R9: While `en_i` is low, no pulse starts.
- R10: While `en_i` is high, `cs_ref_o` rises by one every SS_DIV clocks from zero and saturates at its maximum. It returns to zero one clock after `en_i` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable |
| fb_i | input | FB_W | Feedback code, 1/256 V per LSB |
| cs_trip_i | input | 1 | Current-sense comparator flag |
| gate_o | output | 1 | Gate on request |
| blank_o | output | 1 | Leading-edge blanking window active |
| cs_ref_o | output | REF_W | Soft-start peak-current reference |

## Verification
The bench builds the block with a 40-clock normal period, a 120-clock light-load period, hop depths of 8 and 16, and a four-step hop ramp. It also uses a 5-clock blanking window and a 3-clock soft-start prescaler. With these values a full hop triangle spans only eight cycles, so the exact per-cycle period sequence, band interpolation at mid-band and green end, and the skip hysteresis all fit in a few thousand clocks. The soft-start ramp saturates after 45 clocks, and both its saturation and its clearing are observed.

// File: rtl/gmpwm_pkg.sv
package gmpwm_pkg;
  typedef enum logic {
    HOP_UP   = 1'b0,
    HOP_DOWN = 1'b1
  } hop_dir_e;
endpackage

// File: rtl/gmpwm_freq_map.sv
// Maps the feedback code to a base period and a hop depth (linear in the band).
module gmpwm_freq_map #(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned FB_GREEN  = 589,
  parameter int unsigned BAND_LG   = 7,
  parameter int unsigned PER_NORM  = 1538,
  parameter int unsigned PER_GREEN = 4545,
  parameter int unsigned HOP_NORM  = 98,
  parameter int unsigned HOP_GREEN = 302,
  parameter int unsigned PER_W     = 13
) (
  input  logic [FB_W-1:0]  fb_i,
  output logic [PER_W-1:0] base_o,
  output logic [PER_W-1:0] depth_o
);
  localparam int unsigned SPAN = 1 << BAND_LG;

  logic [31:0] fbv;
  logic [31:0] inv;
  logic [31:0] base_w;
  logic [31:0] depth_w;

  always_comb begin
    fbv = 32'(fb_i);
    if (fbv <= FB_GREEN)             inv = SPAN;
    else if (fbv >= FB_GREEN + SPAN) inv = 32'd0;
    else                             inv = FB_GREEN + SPAN - fbv;
    base_w  = PER_NORM + (((PER_GREEN - PER_NORM) * inv) >> BAND_LG);
    depth_w = HOP_NORM + (((HOP_GREEN - HOP_NORM) * inv) >> BAND_LG);
    base_o  = PER_W'(base_w);
    depth_o = PER_W'(depth_w);
  end
endmodule

// File: rtl/gmpwm_hop.sv
// Triangular hop index, stepped once per switching cycle.
module gmpwm_hop
  import gmpwm_pkg::*;
#(
  parameter int unsigned HOP_LG = 7,
  parameter int unsigned PER_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [PER_W-1:0] base_i,
  input  logic [PER_W-1:0] depth_i,
  output logic [PER_W-1:0] per_o
);
  localparam logic [HOP_LG:0] TOP = (HOP_LG+1)'(1 << HOP_LG);

  logic [HOP_LG:0] idx_q, idx_d;
  hop_dir_e        dir_q, dir_d;
  logic [31:0]     ofs;

  always_comb begin
    idx_d = idx_q;
    dir_d = dir_q;
    if (step_i) begin
      if (dir_q == HOP_UP) begin
        if (idx_q == TOP) begin
          idx_d = TOP - 1'b1;
          dir_d = HOP_DOWN;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        if (idx_q == '0) begin
          idx_d = (HOP_LG+1)'(1);
          dir_d = HOP_UP;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    ofs   = (32'(depth_i) * 32'(idx_q)) >> HOP_LG;
    per_o = PER_W'(32'(base_i) - (32'(depth_i) >> 1) + ofs);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      dir_q <= HOP_UP;
    end else begin
      idx_q <= idx_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/gmpwm_skip.sv
// Hysteretic zero-duty region detector.
module gmpwm_skip #(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned FB_STOP   = 512,
  parameter int unsigned FB_RESUME = 538
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_i,
  output logic            skip_o
);
  logic skip_q, skip_d;

  always_comb begin
    skip_d = skip_q;
    if (32'(fb_i) < FB_STOP)        skip_d = 1'b1;
    else if (32'(fb_i) > FB_RESUME) skip_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_q <= 1'b0;
    else         skip_q <= skip_d;
  end

  assign skip_o = skip_q;
endmodule

// File: rtl/gmpwm_softstart.sv
// Peak-current reference ramp after enable.
module gmpwm_softstart #(
  parameter int unsigned REF_W  = 8,
  parameter int unsigned SS_DIV = 3137
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [REF_W-1:0] ref_o
);
  localparam int unsigned PRE_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SS_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [REF_W-1:0] ref_q, ref_d;

  always_comb begin
    pre_d = pre_q;
    ref_d = ref_q;
    if (!en_i) begin
      pre_d = '0;
      ref_d = '0;
    end else if (ref_q != '1) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        ref_d = ref_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ref_q <= '0;
    end else begin
      pre_q <= pre_d;
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/gmpwm_timebase.sv
// Switching timebase: cycle counter, pulse control, blanking, trip handling.
module gmpwm_timebase #(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned FB_GREEN  = 589,
  parameter int unsigned BAND_LG   = 7,
  parameter int unsigned FB_STOP   = 512,
  parameter int unsigned FB_RESUME = 538,
  parameter int unsigned PER_NORM  = 1538,
  parameter int unsigned PER_GREEN = 4545,
  parameter int unsigned HOP_NORM  = 98,
  parameter int unsigned HOP_GREEN = 302,
  parameter int unsigned HOP_LG    = 7,
  parameter int unsigned DUTY_Q7   = 114,
  parameter int unsigned LEB_CYC   = 28,
  parameter int unsigned REF_W     = 8,
  parameter int unsigned SS_DIV    = 3137
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [FB_W-1:0]  fb_i,
  input  logic             cs_trip_i,
  output logic             gate_o,
  output logic             blank_o,
  output logic [REF_W-1:0] cs_ref_o
);
  localparam int unsigned PER_W = $clog2(PER_GREEN + HOP_GREEN + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync = rst_pipe_q[1];

  logic [PER_W-1:0] base, depth, per_hop;
  logic             skip;
  logic             wrap;

  gmpwm_freq_map #(
    .FB_W(FB_W), .FB_GREEN(FB_GREEN), .BAND_LG(BAND_LG),
    .PER_NORM(PER_NORM), .PER_GREEN(PER_GREEN),
    .HOP_NORM(HOP_NORM), .HOP_GREEN(HOP_GREEN), .PER_W(PER_W)
  ) u_map (
    .fb_i(fb_i), .base_o(base), .depth_o(depth)
  );

  gmpwm_hop #(.HOP_LG(HOP_LG), .PER_W(PER_W)) u_hop (
    .clk_i(clk_i), .rst_ni(rst_sync), .step_i(wrap),
    .base_i(base), .depth_i(depth), .per_o(per_hop)
  );

  gmpwm_skip #(.FB_W(FB_W), .FB_STOP(FB_STOP), .FB_RESUME(FB_RESUME)) u_skip (
    .clk_i(clk_i), .rst_ni(rst_sync), .fb_i(fb_i), .skip_o(skip)
  );

  gmpwm_softstart #(.REF_W(REF_W), .SS_DIV(SS_DIV)) u_ss (
    .clk_i(clk_i), .rst_ni(rst_sync), .en_i(en_i), .ref_o(cs_ref_o)
  );

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] onmax_q, onmax_d;
  logic             gate_q, gate_d;
  logic             in_blank;
  logic             trip_hit;
  logic [31:0]      onmax_w;

  always_comb begin
    wrap     = (cnt_q >= per_q - 1'b1);
    in_blank = gate_q && (32'(cnt_q) < LEB_CYC);
    trip_hit = gate_q && !in_blank && cs_trip_i;
    onmax_w  = (32'(per_hop) * DUTY_Q7) >> 7;
    cnt_d    = wrap ? '0 : cnt_q + 1'b1;
    per_d    = per_q;
    onmax_d  = onmax_q;
    if (wrap) begin
      per_d   = per_hop;
      onmax_d = PER_W'(onmax_w);
      gate_d  = en_i && !skip && (onmax_w != 32'd0);
    end else begin
      gate_d  = gate_q && !trip_hit && (cnt_d < onmax_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync) begin
    if (!rst_sync) begin
      cnt_q   <= '0;
      per_q   <= PER_W'(1);
      onmax_q <= '0;
      gate_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      onmax_q <= onmax_d;
      gate_q  <= gate_d;
    end
  end

  assign gate_o  = gate_q;
  assign blank_o = in_blank;
endmodule

// File: rtl/gmpwm_timebase_sva.sv
module gmpwm_timebase_sva #(
  parameter int unsigned REF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             cs_trip_i,
  input logic             gate_o,
  input logic             blank_o,
  input logic [REF_W-1:0] cs_ref_o
);
  a_r6_blank_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> gate_o);

  a_r6_blank_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> blank_o);

  a_r7_trip_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !blank_o && cs_trip_i) |=> (!gate_o || blank_o));

  a_r9_rise_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(en_i));

  a_r10_ref_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> (cs_ref_o >= $past(cs_ref_o)));

  a_r10_ref_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cs_ref_o == '0));
endmodule

bind gmpwm_timebase gmpwm_timebase_sva #(.REF_W(REF_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_sync), .en_i(en_i), .cs_trip_i(cs_trip_i),
  .gate_o(gate_o), .blank_o(blank_o), .cs_ref_o(cs_ref_o)
);

// File: tb/gmpwm_timebase_test.sv
`timescale 1ns/1ps
module gmpwm_timebase_test;
  localparam int PN = 40, PG = 120, HN = 8, HG = 16, HLG = 2;
  localparam int LEB = 5, SSD = 3, RW = 4, DQ = 114;
  localparam int FB_NORM_C = 717, FB_MID_C = 653, FB_GREEN_C = 589;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [9:0] fb = 10'd717;
  logic trip = 1'b0;
  logic gate, blank;
  logic [RW-1:0] ref_c;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gmpwm_timebase #(
    .FB_W(10), .FB_GREEN(589), .BAND_LG(7), .FB_STOP(512), .FB_RESUME(538),
    .PER_NORM(PN), .PER_GREEN(PG), .HOP_NORM(HN), .HOP_GREEN(HG), .HOP_LG(HLG),
    .DUTY_Q7(DQ), .LEB_CYC(LEB), .REF_W(RW), .SS_DIV(SSD)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fb_i(fb), .cs_trip_i(trip),
    .gate_o(gate), .blank_o(blank), .cs_ref_o(ref_c)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int onmax(input int per);
    return (per * DQ) >> 7;
  endfunction

  // clocks until the next gate rise, sampled on falling edges
  task automatic next_rise(output int n);
    logic prev = gate;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if (!prev && gate) return;
      prev = gate;
    end
    n = -1;
  endtask

  task automatic count_rises(input int span, output int rises);
    logic prev = gate;
    rises = 0;
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      if (!prev && gate) rises++;
      prev = gate;
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 gate in reset", gate, 0);
    check("R1 blank in reset", blank, 0);
    check("R1 ref in reset", ref_c, 0);
  endtask

  task automatic t_hop_sequence();
    int n, sum, w;
    int exp_idx[8] = '{0, 1, 2, 3, 4, 3, 2, 1};
    en = 1'b1;
    fb = 10'(FB_NORM_C);
    @(negedge clk);
    rst_n = 1'b1;
    next_rise(n);
    // first pulse width (R5) on the idx-0 cycle of 36 clocks
    w = 1;
    while (1) begin @(negedge clk); if (gate) w++; else break; end
    check("R5 pulse width at max duty", w, onmax(36));
    n = w;
    begin int r; next_rise(r); n += r; end
    check("R4 hop cycle 0", n, 36);
    sum = n;
    for (int c = 1; c < 8; c++) begin
      next_rise(n);
      check("R4 hop cycle", n, PN - HN/2 + ((HN * exp_idx[c]) >> HLG));
      sum += n;
    end
    check("R2 mean normal period", sum, 8 * PN);
  endtask

  task automatic t_band(input int fbc, input int base, input int depth, input string tag);
    int n, sum, mn, mx;
    fb = 10'(fbc);
    next_rise(n); next_rise(n);
    sum = 0; mn = 100000; mx = 0;
    for (int c = 0; c < 8; c++) begin
      next_rise(n);
      sum += n;
      if (n < mn) mn = n;
      if (n > mx) mx = n;
    end
    check({tag, " base period sum"}, sum, 8 * base);
    check({tag, " hop depth"}, mx - mn, depth);
    fb = 10'(FB_NORM_C);
    next_rise(n); next_rise(n);
  endtask

  task automatic t_blank_ignore();
    int n, w, bl, rest;
    next_rise(n);
    trip = 1'b1;
    w = 1; bl = blank ? 1 : 0;
    repeat (LEB) begin
      @(negedge clk);
      if (gate) w++;
      if (blank) bl++;
    end
    trip = 1'b0;
    while (gate) begin @(negedge clk); if (gate) w++; end
    next_rise(rest);
    check("R6 blank width", bl, LEB);
    check("R6 trip in blank ignored", w, onmax(w + rest));
  endtask

  task automatic t_mid_trip();
    int n, w, g_after;
    next_rise(n);
    w = 1;
    repeat (10) begin @(negedge clk); if (gate) w++; end
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    g_after = gate;
    check("R7 width ended by trip", w, 11);
    check("R7 gate low after trip", g_after, 0);
    repeat (5) @(negedge clk);
    check("R7 no restart in cycle", gate, 0);
  endtask

  task automatic t_trip_held();
    int n, w;
    trip = 1'b1;
    next_rise(n);
    w = 1;
    while (1) begin @(negedge clk); if (gate) w++; else break; end
    trip = 1'b0;
    check("R7 R6 held trip width", w, LEB + 1);
  endtask

  task automatic t_skip();
    int r;
    fb = 10'd525;
    count_rises(300, r);
    check("R8 between levels keeps running", r > 0, 1);
    fb = 10'd500;
    repeat (150) @(negedge clk);
    count_rises(300, r);
    check("R8 stop below low level", r, 0);
    fb = 10'd525;
    count_rises(300, r);
    check("R8 between levels stays stopped", r, 0);
    fb = 10'd545;
    count_rises(300, r);
    check("R8 resume above high level", r > 0, 1);
    fb = 10'(FB_NORM_C);
  endtask

  task automatic t_enable_softstart();
    int r;
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 ref cleared", ref_c, 0);
    repeat (60) @(negedge clk);
    count_rises(200, r);
    check("R9 no pulse while disabled", r, 0);
    en = 1'b1;
    repeat (5 * SSD) @(negedge clk);
    check("R10 ref after five steps", ref_c, 5);
    repeat (10 * SSD) @(negedge clk);
    check("R10 ref at full scale", ref_c, 15);
    repeat (20) @(negedge clk);
    check("R10 ref saturates", ref_c, 15);
    count_rises(200, r);
    check("R9 pulses resume with enable", r > 0, 1);
  endtask

  initial begin
    t_reset();
    t_hop_sequence();
    t_band(FB_MID_C, 80, 12, "R3 mid band");
    t_band(FB_GREEN_C, PG, HG, "R3 green end");
    t_blank_ignore();
    t_mid_trip();
    t_trip_held();
    t_skip();
    t_enable_softstart();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule